// File: doc/BRIEF.md
# Coherence Permission Balance Checker

This block checks, while the system runs, that every gain of access rights to a cache block is paid for by matching losses of rights somewhere else. Each cache or memory controller has its own signature register. When a controller gains rights to a block (for example, from no access to read access), it adds the block address to its signature. When it gives rights up (for example, from write access to read access), it subtracts the address.

A single upgrade can force several controllers to give up rights, and the upgrader cannot know in advance how many will do so. For that reason the upgrade lane has a weight input. The weight is the number of give-up acknowledgements the upgrader collected, and the block adds the address multiplied by that weight. All arithmetic is modulo 2^SIG_W, so wraparound never causes a false error.

A logical-time epoch lasts EPOCH_LEN broadcast request ticks. On the tick that closes an epoch, a shared summing unit adds all signatures. The block then reports the result on a one-cycle done strobe with an error flag, and it clears every signature in the same step. The coherence protocol engine that produces the events lies outside this block.

Top module: `coh_balance_checker`

## Requirements
- R1: An upgrade on a controller's lane (up_vld bit i) adds up_addr lane i multiplied by up_wt lane i to that controller's signature, modulo 2^SIG_W. Lanes are ADDR_W and WT_W bits wide, and lane i occupies bits starting at i*width.
- R2: A downgrade on lane i (dn_vld bit i) subtracts dn_addr lane i from that controller's signature.
- R3: If an upgrade and a downgrade reach the same controller in one cycle, both are applied as their net change. Neither one is lost.
- R4: Each cycle in which req_tick is high counts as one tick, and cycles without req_tick do not count. The epoch closes on the EPOCH_LEN-th tick. chk_done is high for exactly the one cycle after the closing tick and is low at all other times.
- R5: chk_err is high together with chk_done when the modulo-2^SIG_W sum of all signatures, taken before the closing cycle's events, is non-zero. chk_err is never high without chk_done.
- R6: When an epoch closes, every signature is cleared. Events that arrive in the closing cycle count toward the next epoch.
- R7: A set of events that balances modulo 2^SIG_W reports no error, even when the partial products or sums overflow.
- R8: Reset (rst_n low) clears all signatures and the tick count, and holds chk_done and chk_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_tick | input | 1 | One broadcast request observed (advances logical time) |
| up_vld | input | N_CTRL | Per-controller upgrade strobe |
| up_addr | input | N_CTRL*ADDR_W | Per-controller upgrade block address |
| up_wt | input | N_CTRL*WT_W | Per-controller upgrade weight (count of downgrade acks) |
| dn_vld | input | N_CTRL | Per-controller downgrade strobe |
| dn_addr | input | N_CTRL*ADDR_W | Per-controller downgrade block address |
| chk_done | output | 1 | One-cycle strobe: an epoch check has completed |
| chk_err | output | 1 | With chk_done: the global signature sum was non-zero |

## Verification
The check-and-clear step can fall in the same cycle as a new upgrade or downgrade. The bench provokes this by placing an upgrade on the tick that closes an epoch and the matching downgrade early in the next epoch. It then expects both checks to report no error, which is only correct if the closing-cycle event was carried into the new epoch rather than lost or counted in the old one. A second same-cycle case gives one controller an upgrade and a downgrade of different addresses at once, and the result is judged only by the balance at the end of the epoch.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
   // Reduction structure used by the global summing unit
   typedef enum logic [0:0] {
      SUM_TREE  = 1'b0,   // log2(N) adder levels
      SUM_CHAIN = 1'b1    // N-1 adders in series
   } sum_style_e;
endpackage

// File: rtl/cbc_sig_acc.sv
module cbc_sig_acc #(
   parameter int ADDR_W = 32,
   parameter int SIG_W  = 32,
   parameter int WT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              up_vld,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [WT_W-1:0]   up_wt,
   input  logic              dn_vld,
   input  logic [ADDR_W-1:0] dn_addr,
   output logic [SIG_W-1:0]  sig
);
   logic [SIG_W-1:0] up_ext, wt_ext, dn_ext, up_term, dn_term, delta;

   always_comb begin
      up_ext  = SIG_W'(up_addr);
      wt_ext  = SIG_W'(up_wt);
      dn_ext  = SIG_W'(dn_addr);
      up_term = up_vld ? up_ext * wt_ext : '0;
      dn_term = dn_vld ? dn_ext : '0;
      delta   = up_term - dn_term;
   end

   // clear and same-cycle event: the event seeds the next epoch
   always_ff @(posedge clk) begin
      if (!rst_n)   sig <= '0;
      else if (clr) sig <= delta;
      else          sig <= sig + delta;
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_vld && !dn_vld && !clr) |=> $stable(sig)); // R1
   AST_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (up_vld && dn_vld && SIG_W'(up_addr) == SIG_W'(dn_addr) && up_wt == WT_W'(1) && !clr)
      |=> $stable(sig)); // R3
endmodule

// File: rtl/cbc_epoch_ctr.sv
module cbc_epoch_ctr #(
   parameter int EPOCH_LEN = 3000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic epoch_end
);
   localparam int CNT_W = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(EPOCH_LEN - 1);

   logic [CNT_W-1:0] cnt;

   assign epoch_end = tick && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R4
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt)); // R4
endmodule

// File: rtl/cbc_sum.sv
module cbc_sum
   import cbc_pkg::*;
#(
   parameter int         N_CTRL    = 4,
   parameter int         SIG_W     = 32,
   parameter sum_style_e SUM_STYLE = SUM_TREE
) (
   input  logic [N_CTRL*SIG_W-1:0] sig_flat,
   output logic [SIG_W-1:0]        total
);
   generate
      if (SUM_STYLE == SUM_TREE) begin : g_tree
         localparam int LVL = $clog2(N_CTRL);
         localparam int P   = 1 << LVL;
         logic [SIG_W-1:0] node [2*P-1];
         for (genvar i = 0; i < P; i++) begin : g_leaf
            if (i < N_CTRL) begin : g_used
               assign node[P-1+i] = sig_flat[i*SIG_W +: SIG_W];
            end else begin : g_pad
               assign node[P-1+i] = '0;
            end
         end
         for (genvar k = 0; k < P-1; k++) begin : g_node
            assign node[k] = node[2*k+1] + node[2*k+2];
         end
         assign total = node[0];
      end else begin : g_chain
         always_comb begin
            total = '0;
            for (int i = 0; i < N_CTRL; i++) total = total + sig_flat[i*SIG_W +: SIG_W];
         end
      end
   endgenerate
endmodule

// File: rtl/coh_balance_checker.sv
module coh_balance_checker
   import cbc_pkg::*;
#(
   parameter int         N_CTRL    = 4,
   parameter int         ADDR_W    = 32,
   parameter int         SIG_W     = 32,
   parameter int         WT_W      = 4,
   parameter int         EPOCH_LEN = 3000,
   parameter sum_style_e SUM_STYLE = SUM_TREE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_tick,
   input  logic [N_CTRL-1:0]        up_vld,
   input  logic [N_CTRL*ADDR_W-1:0] up_addr,
   input  logic [N_CTRL*WT_W-1:0]   up_wt,
   input  logic [N_CTRL-1:0]        dn_vld,
   input  logic [N_CTRL*ADDR_W-1:0] dn_addr,
   output logic                     chk_done,
   output logic                     chk_err
);
   generate
      if (N_CTRL < 1)     begin : g_bad_n   $error("N_CTRL must be at least 1");     end
      if (ADDR_W > SIG_W) begin : g_bad_w   $error("ADDR_W must not exceed SIG_W");  end
      if (WT_W < 1)       begin : g_bad_wt  $error("WT_W must be at least 1");       end
      if (EPOCH_LEN < 1)  begin : g_bad_len $error("EPOCH_LEN must be at least 1"); end
   endgenerate

   logic                    epoch_end;
   logic [N_CTRL*SIG_W-1:0] sig_flat;
   logic [SIG_W-1:0]        total;

   cbc_epoch_ctr #(.EPOCH_LEN(EPOCH_LEN)) u_epoch (
      .clk(clk), .rst_n(rst_n), .tick(req_tick), .epoch_end(epoch_end)
   );

   for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
      cbc_sig_acc #(.ADDR_W(ADDR_W), .SIG_W(SIG_W), .WT_W(WT_W)) u_acc (
         .clk(clk), .rst_n(rst_n), .clr(epoch_end),
         .up_vld(up_vld[i]), .up_addr(up_addr[i*ADDR_W +: ADDR_W]), .up_wt(up_wt[i*WT_W +: WT_W]),
         .dn_vld(dn_vld[i]), .dn_addr(dn_addr[i*ADDR_W +: ADDR_W]),
         .sig(sig_flat[i*SIG_W +: SIG_W])
      );
   end

   cbc_sum #(.N_CTRL(N_CTRL), .SIG_W(SIG_W), .SUM_STYLE(SUM_STYLE)) u_sum (
      .sig_flat(sig_flat), .total(total)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_done <= 1'b0;
         chk_err  <= 1'b0;
      end else begin
         chk_done <= epoch_end;
         chk_err  <= epoch_end && (total != '0);
      end
   end

   AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      epoch_end |=> chk_done); // R4
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (EPOCH_LEN > 1 && chk_done) |=> !chk_done); // R4
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_err |-> chk_done); // R5
endmodule

// File: tb/tb_coh_balance_checker.sv
`timescale 1ns/1ps
module tb_coh_balance_checker;
   localparam int N = 4;
   localparam int AW = 32;
   localparam int WW = 4;

   typedef struct packed {
      logic [3:0]  up;
      logic [3:0]  dn;
      logic [31:0] ua;
      logic [31:0] da;
      logic [3:0]  wt;
   } step_t;

   typedef struct packed {
      step_t s0;
      step_t s1;
      step_t s2;
      logic  exp_err;
   } row_t;

   function automatic step_t st(logic [3:0] up, logic [3:0] dn, logic [31:0] ua,
                                logic [31:0] da, logic [3:0] wt);
      st = '{up: up, dn: dn, ua: ua, da: da, wt: wt};
   endfunction

   localparam step_t Z = '0;
   localparam int NROWS = 9;
   localparam row_t ROWS [NROWS] = '{
      // R1 R2: writer c0 upgrades weight 3, sharers c1..c3 give up
      {st(4'b0001, 4'b1110, 32'h1000, 32'h1000, 4'd3), Z, Z, 1'b0},
      // lost downgrade: c3 never reports
      {st(4'b0001, 4'b0110, 32'h1000, 32'h1000, 4'd3), Z, Z, 1'b1},
      // R6: idle epoch right after an error must be clean
      {Z, Z, Z, 1'b0},
      // duplicated upgrade
      {st(4'b0001, 4'b0010, 32'h2040, 32'h2040, 4'd1), st(4'b0001, 4'b0000, 32'h2040, 32'h0, 4'd1), Z, 1'b1},
      // wrongly weighted multi-sharer upgrade
      {st(4'b0001, 4'b1110, 32'h3300, 32'h3300, 4'd2), Z, Z, 1'b1},
      // R7: product and sum wrap modulo 2^32
      {st(4'b0100, 4'b1011, 32'hC000_0000, 32'hC000_0000, 4'd3), Z, Z, 1'b0},
      // reads granted by memory controller c3, over two cycles
      {st(4'b0010, 4'b1000, 32'h80, 32'h80, 4'd1), st(4'b0100, 4'b1000, 32'h80, 32'h80, 4'd1), Z, 1'b0},
      // R3: c1 upgrades 0x300 and downgrades 0x500 in one cycle, balanced later
      {{4'b0010, 4'b0010, 32'h300, 32'h500, 4'd1}, st(4'b1000, 4'b0100, 32'h500, 32'h300, 4'd1), Z, 1'b0},
      // R3: same, but 0x500 is never regained
      {{4'b0010, 4'b0010, 32'h300, 32'h500, 4'd1}, st(4'b0000, 4'b0100, 32'h0, 32'h300, 4'd1), Z, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_tick = 1'b0;
   logic [N-1:0] up_vld = '0, dn_vld = '0;
   logic [N*AW-1:0] up_addr = '0, dn_addr = '0;
   logic [N*WW-1:0] up_wt = '0;
   logic chk_done, chk_err;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   coh_balance_checker #(.N_CTRL(N), .ADDR_W(AW), .SIG_W(32), .WT_W(WW), .EPOCH_LEN(4)) dut (
      .clk(clk), .rst_n(rst_n), .req_tick(req_tick),
      .up_vld(up_vld), .up_addr(up_addr), .up_wt(up_wt),
      .dn_vld(dn_vld), .dn_addr(dn_addr),
      .chk_done(chk_done), .chk_err(chk_err)
   );

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // waits for a falling edge, then drives one cycle of stimulus
   task automatic drive(step_t s, logic tick);
      @(negedge clk);
      req_tick = tick;
      up_vld   = s.up;
      dn_vld   = s.dn;
      up_addr  = {N{s.ua}};
      dn_addr  = {N{s.da}};
      up_wt    = {N{s.wt}};
   endtask

   task automatic close_and_check(step_t last, logic exp_err, string tag);
      drive(last, 1'b1);
      drive(Z, 1'b0);
      chk({tag, " R4 done"}, chk_done, 1'b1);
      chk({tag, " R5 err"}, chk_err, exp_err);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 done in reset", chk_done, 1'b0);
      chk("R8 err in reset", chk_err, 1'b0);
      rst_n = 1'b1;

      // vector table: three event ticks plus an empty closing tick
      for (int r = 0; r < NROWS; r++) begin
         drive(ROWS[r].s0, 1'b1);
         drive(ROWS[r].s1, 1'b1);
         drive(ROWS[r].s2, 1'b1);
         close_and_check(Z, ROWS[r].exp_err, $sformatf("row%0d", r));
      end

      // R4: cycles without a tick do not advance the epoch
      drive(st(4'b0001, 4'b0000, 32'h10, 32'h0, 4'd1), 1'b1);
      drive(Z, 1'b0);
      drive(st(4'b0000, 4'b0100, 32'h0, 32'h10, 4'd0), 1'b1);
      drive(Z, 1'b0);
      drive(Z, 1'b1);
      drive(Z, 1'b0);
      chk("R4 no early done", chk_done, 1'b0);
      close_and_check(Z, 1'b0, "gapped");
      drive(Z, 1'b0);
      chk("R4 done single cycle", chk_done, 1'b0);

      // R6: upgrade on the closing tick belongs to the next epoch
      drive(Z, 1'b1);
      drive(Z, 1'b1);
      drive(Z, 1'b1);
      close_and_check(st(4'b0001, 4'b0000, 32'h44, 32'h0, 4'd1), 1'b0, "R6 closing event");
      drive(st(4'b0000, 4'b0010, 32'h0, 32'h44, 4'd0), 1'b1);
      drive(Z, 1'b1);
      drive(Z, 1'b1);
      close_and_check(Z, 1'b0, "R6 carried event");

      // R8: reset in mid-epoch drops count and signatures
      drive(st(4'b0001, 4'b0000, 32'h99, 32'h0, 4'd1), 1'b1);
      drive(Z, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      req_tick = 1'b0;
      up_vld = '0;
      @(negedge clk);
      chk("R8 done mid reset", chk_done, 1'b0);
      rst_n = 1'b1;
      drive(Z, 1'b1);
      drive(Z, 1'b1);
      drive(Z, 1'b1);
      chk("R8 count restarted", chk_done, 1'b0);
      close_and_check(Z, 1'b0, "R8 after reset");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL R4 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule